// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a raster display: sync, blanking and active-picture strobes for each axis, the current dot and line counts, and a one-dot frame-start marker. Each axis is described by four 16-bit values. Each value is the inclusive last count of a phase, not a width. The phases follow one another as sync, blank, visible picture and end of line or frame. So a phase programmed to N lasts N+1 counts, and a line with a total of 454 is 455 dots long.

Software programs the block through a small word-addressed register port. Timing and flip words are double-buffered. A write lands at once in a shadow copy, which reads back on the next cycle. The counters and strobes go on using the previous set until the frame wraps, so a frame is never split between two timings. A further group of zoom and scroll words, and the spare bits of the control word, are held for readback only. A single clock enable marks each dot. The block steps only on cycles where that enable is high.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset both counters are 0 and every register reads back its parameter default. The defaults are horizontal sync/blank/screen/total ends 42, 111, 495, 454, vertical ends 3, 21, 245, 262, zoom words 0, 0, 1023, 64 and control 0x0003.
- R2: `hcount` advances by one on each clock where `dot_en` is high and holds otherwise. After reaching the horizontal total end it returns to 0, giving total+1 dots per line.
- R3: `vcount` advances by one each time `hcount` wraps and holds otherwise. After reaching the vertical total end it returns to 0, giving total+1 lines per frame.
- R4: On each axis, sync is high for counts 0 through the sync end inclusive and low above it.
- R5: On each axis, active is high for counts above the blank end that are at or below both the screen end and the total end. Blank is the complement of active.
- R6: `frame_start` is high exactly while both counters are 0.
- R7: A write to a timing or flip register has no effect on counters or strobes until the counters wrap from (total, total) to (0, 0). The new values govern the frame that begins at that wrap.
- R8: Byte offsets 0x60/0x62/0x64/0x66 hold horizontal sync/blank/screen/total ends. 0x70/0x72/0x74/0x76 hold the same for vertical. 0x80 is control. `reg_rdata` returns the addressed word one cycle after it is written. Odd or other offsets read 0, and writes to them change nothing.
- R9: Words 0x68–0x6E and 0x78–0x7E, and control bits other than 4:3, are stored and read back but do not change any timing output.
- R10: Control bit 3 drives `flip_x` and bit 4 drives `flip_y`. Both take effect at the frame wrap, like the timing words.
- R11: With default parameters the first line lasts exactly 455 enabled dots before `vcount` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_en | input | 1 | One-cycle dot enable; counters step only when high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Shadow contents of the addressed word, 0 if unmapped |
| hcount | output | 16 | Dot counter |
| vcount | output | 16 | Line counter |
| hsync | output | 1 | Horizontal sync |
| hblank | output | 1 | Horizontal blanking |
| hactive | output | 1 | Horizontal active picture |
| vsync | output | 1 | Vertical sync |
| vblank | output | 1 | Vertical blanking |
| vactive | output | 1 | Vertical active picture |
| frame_start | output | 1 | High while both counters are 0 |
| flip_x | output | 1 | Horizontal flip in force for this frame |
| flip_y | output | 1 | Vertical flip in force for this frame |

## Verification
The counters are the only registers between `dot_en` and the strobes, so every strobe and `frame_start` is due in the cycle after the clock edge that samples an enabled dot. A written word is visible on `reg_rdata` in the cycle after the write edge. It reaches the timing outputs only in the cycle after the edge that wraps both counters. The bench drives all inputs on the falling edge and steps a model of its own on each rising edge, using the pre-edge shadow values for a wrap that coincides with a write. It compares every output on the next falling edge, so each result is sampled in the cycle it is due.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int RW        = 16;
  localparam int AW        = 8;
  localparam int NUM_WORDS = 17;
  localparam int IDX_W     = $clog2(NUM_WORDS);
  localparam int CTRL_IDX  = NUM_WORDS - 1;

  localparam logic [AW-1:0] WIN_FIRST = 8'h60;
  localparam logic [AW-1:0] WIN_LAST  = 8'h7E;
  localparam logic [AW-1:0] CTRL_OFS  = 8'h80;

  localparam int FLIP_X_BIT = 3;
  localparam int FLIP_Y_BIT = 4;

  localparam logic [RW-1:0] ZOOM_MASTER_INIT = 16'd0;
  localparam logic [RW-1:0] ZOOM_OFFSET_INIT = 16'd0;
  localparam logic [RW-1:0] ZOOM_SIZE_INIT   = 16'd1023;
  localparam logic [RW-1:0] ZOOM_SCALE_INIT  = 16'd64;

  typedef struct packed {
    logic [RW-1:0] sync_end;
    logic [RW-1:0] blank_end;
    logic [RW-1:0] screen_end;
    logic [RW-1:0] total_end;
  } axis_timing_t;

  typedef struct packed {
    axis_timing_t h;
    axis_timing_t v;
    logic         flip_x;
    logic         flip_y;
  } raster_cfg_t;

  function automatic raster_cfg_t make_cfg(
    input logic [RW-1:0] hs, input logic [RW-1:0] hb,
    input logic [RW-1:0] hsc, input logic [RW-1:0] ht,
    input logic [RW-1:0] vs, input logic [RW-1:0] vb,
    input logic [RW-1:0] vsc, input logic [RW-1:0] vt,
    input logic fx, input logic fy);
    raster_cfg_t c;
    c.h.sync_end   = hs;
    c.h.blank_end  = hb;
    c.h.screen_end = hsc;
    c.h.total_end  = ht;
    c.v.sync_end   = vs;
    c.v.blank_end  = vb;
    c.v.screen_end = vsc;
    c.v.total_end  = vt;
    c.flip_x       = fx;
    c.flip_y       = fy;
    return c;
  endfunction

endpackage

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter logic [RW-1:0] H_SYNC_END   = 16'd42,
  parameter logic [RW-1:0] H_BLANK_END  = 16'd111,
  parameter logic [RW-1:0] H_SCREEN_END = 16'd495,
  parameter logic [RW-1:0] H_TOTAL_END  = 16'd454,
  parameter logic [RW-1:0] V_SYNC_END   = 16'd3,
  parameter logic [RW-1:0] V_BLANK_END  = 16'd21,
  parameter logic [RW-1:0] V_SCREEN_END = 16'd245,
  parameter logic [RW-1:0] V_TOTAL_END  = 16'd262,
  parameter logic [RW-1:0] CTRL_INIT    = 16'h0003
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [RW-1:0] wdata,
  input  logic          load,
  output logic [RW-1:0] rdata,
  output raster_cfg_t   act_cfg
);

  localparam logic [RW-1:0] DFLT [NUM_WORDS] = '{
    H_SYNC_END, H_BLANK_END, H_SCREEN_END, H_TOTAL_END,
    ZOOM_MASTER_INIT, ZOOM_OFFSET_INIT, ZOOM_SIZE_INIT, ZOOM_SCALE_INIT,
    V_SYNC_END, V_BLANK_END, V_SCREEN_END, V_TOTAL_END,
    ZOOM_MASTER_INIT, ZOOM_OFFSET_INIT, ZOOM_SIZE_INIT, ZOOM_SCALE_INIT,
    CTRL_INIT
  };

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [RW-1:0]    word_q [NUM_WORDS];
  raster_cfg_t      shadow_cfg;
  raster_cfg_t      act_d;
  raster_cfg_t      act_q;

  // address decode: even offsets in the timing window, plus the control word
  always_comb begin
    hit = 1'b0;
    idx = '0;
    if (!addr[0]) begin
      if (addr >= WIN_FIRST && addr <= WIN_LAST) begin
        hit = 1'b1;
        idx = IDX_W'((addr - WIN_FIRST) >> 1);
      end else if (addr == CTRL_OFS) begin
        hit = 1'b1;
        idx = IDX_W'(CTRL_IDX);
      end
    end
  end

  // shadow words: written immediately, read back on the following cycle
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    logic          sel;
    logic [RW-1:0] d;
    logic [RW-1:0] q;

    assign sel = wr_en && hit && (idx == IDX_W'(i));

    always_comb begin
      d = q;
      if (sel) d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= DFLT[i];
      else        q <= d;
    end

    assign word_q[i] = q;
  end

  assign rdata = hit ? word_q[idx] : '0;

  // working copy that drives timing, refreshed only at the frame wrap
  always_comb begin
    shadow_cfg = make_cfg(word_q[0], word_q[1], word_q[2], word_q[3],
                          word_q[8], word_q[9], word_q[10], word_q[11],
                          word_q[CTRL_IDX][FLIP_X_BIT],
                          word_q[CTRL_IDX][FLIP_Y_BIT]);
    act_d = act_q;
    if (load) act_d = shadow_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= make_cfg(DFLT[0], DFLT[1], DFLT[2], DFLT[3],
                                  DFLT[8], DFLT[9], DFLT[10], DFLT[11],
                                  DFLT[CTRL_IDX][FLIP_X_BIT],
                                  DFLT[CTRL_IDX][FLIP_Y_BIT]);
    else        act_q <= act_d;
  end

  assign act_cfg = act_q;

endmodule

// File: rtl/raster_axis_ctr.sv
module raster_axis_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] last,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  logic [CW-1:0] cnt_d;
  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == last);
  assign wrap    = step && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (step) begin
      if (at_last) cnt_d = '0;
      else         cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/raster_region.sv
module raster_region #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] sync_end,
  input  logic [CW-1:0] blank_end,
  input  logic [CW-1:0] screen_end,
  input  logic [CW-1:0] total_end,
  output logic          sync,
  output logic          blank,
  output logic          active
);

  logic past_blank;
  logic in_screen;
  logic in_line;

  assign past_blank = (cnt > blank_end);
  assign in_screen  = (cnt <= screen_end);
  assign in_line    = (cnt <= total_end);

  assign sync   = (cnt <= sync_end);
  assign active = past_blank && in_screen && in_line;
  assign blank  = !active;

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter logic [RW-1:0] H_SYNC_END   = 16'd42,
  parameter logic [RW-1:0] H_BLANK_END  = 16'd111,
  parameter logic [RW-1:0] H_SCREEN_END = 16'd495,
  parameter logic [RW-1:0] H_TOTAL_END  = 16'd454,
  parameter logic [RW-1:0] V_SYNC_END   = 16'd3,
  parameter logic [RW-1:0] V_BLANK_END  = 16'd21,
  parameter logic [RW-1:0] V_SCREEN_END = 16'd245,
  parameter logic [RW-1:0] V_TOTAL_END  = 16'd262,
  parameter logic [RW-1:0] CTRL_INIT    = 16'h0003
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dot_en,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic [RW-1:0] hcount,
  output logic [RW-1:0] vcount,
  output logic          hsync,
  output logic          hblank,
  output logic          hactive,
  output logic          vsync,
  output logic          vblank,
  output logic          vactive,
  output logic          frame_start,
  output logic          flip_x,
  output logic          flip_y
);

  localparam int NAX = 2;

  raster_cfg_t   act_cfg;
  logic          h_wrap;
  logic          v_wrap;
  logic          frame_wrap;

  logic [RW-1:0] act_h_sync, act_h_blank, act_h_screen, act_h_total;
  logic [RW-1:0] act_v_sync, act_v_blank, act_v_screen, act_v_total;

  axis_timing_t  axis_cfg    [NAX];
  logic [RW-1:0] axis_cnt    [NAX];
  logic          axis_sync   [NAX];
  logic          axis_blank  [NAX];
  logic          axis_active [NAX];

  assign frame_wrap = v_wrap;

  raster_regs #(
    .H_SYNC_END  (H_SYNC_END),
    .H_BLANK_END (H_BLANK_END),
    .H_SCREEN_END(H_SCREEN_END),
    .H_TOTAL_END (H_TOTAL_END),
    .V_SYNC_END  (V_SYNC_END),
    .V_BLANK_END (V_BLANK_END),
    .V_SCREEN_END(V_SCREEN_END),
    .V_TOTAL_END (V_TOTAL_END),
    .CTRL_INIT   (CTRL_INIT)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .load   (frame_wrap),
    .rdata  (reg_rdata),
    .act_cfg(act_cfg)
  );

  assign act_h_sync   = act_cfg.h.sync_end;
  assign act_h_blank  = act_cfg.h.blank_end;
  assign act_h_screen = act_cfg.h.screen_end;
  assign act_h_total  = act_cfg.h.total_end;
  assign act_v_sync   = act_cfg.v.sync_end;
  assign act_v_blank  = act_cfg.v.blank_end;
  assign act_v_screen = act_cfg.v.screen_end;
  assign act_v_total  = act_cfg.v.total_end;

  raster_axis_ctr #(.CW(RW)) u_hctr (
    .clk  (clk),
    .rst_n(rst_n),
    .step (dot_en),
    .last (act_h_total),
    .cnt  (hcount),
    .wrap (h_wrap)
  );

  raster_axis_ctr #(.CW(RW)) u_vctr (
    .clk  (clk),
    .rst_n(rst_n),
    .step (h_wrap),
    .last (act_v_total),
    .cnt  (vcount),
    .wrap (v_wrap)
  );

  assign axis_cfg[0] = act_cfg.h;
  assign axis_cfg[1] = act_cfg.v;
  assign axis_cnt[0] = hcount;
  assign axis_cnt[1] = vcount;

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    raster_region #(.CW(RW)) u_region (
      .cnt       (axis_cnt[a]),
      .sync_end  (axis_cfg[a].sync_end),
      .blank_end (axis_cfg[a].blank_end),
      .screen_end(axis_cfg[a].screen_end),
      .total_end (axis_cfg[a].total_end),
      .sync      (axis_sync[a]),
      .blank     (axis_blank[a]),
      .active    (axis_active[a])
    );
  end

  assign hsync   = axis_sync[0];
  assign hblank  = axis_blank[0];
  assign hactive = axis_active[0];
  assign vsync   = axis_sync[1];
  assign vblank  = axis_blank[1];
  assign vactive = axis_active[1];

  assign frame_start = (hcount == '0) && (vcount == '0);
  assign flip_x      = act_cfg.flip_x;
  assign flip_y      = act_cfg.flip_y;

endmodule

// File: rtl/raster_timing_gen_checker.sv
module raster_timing_gen_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        dot_en,
  input logic [15:0] hcount,
  input logic [15:0] vcount,
  input logic        hsync,
  input logic        hactive,
  input logic        frame_start,
  input logic        flip_x,
  input logic        flip_y,
  input logic [15:0] act_h_sync,
  input logic [15:0] act_h_blank,
  input logic [15:0] act_h_screen,
  input logic [15:0] act_h_total,
  input logic [15:0] act_v_sync,
  input logic [15:0] act_v_blank,
  input logic [15:0] act_v_screen,
  input logic [15:0] act_v_total
);

  logic line_end;
  logic frame_end;

  assign line_end  = dot_en && (hcount == act_h_total);
  assign frame_end = line_end && (vcount == act_v_total);

  assert_hcount_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_en |=> $stable(hcount));

  assert_hcount_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hcount <= act_h_total);

  assert_vcount_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(vcount));

  assert_hsync_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync) |-> ({1'b0, hcount} == {1'b0, act_h_sync} + 17'd1));

  assert_hactive_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hactive) |-> ({1'b0, hcount} == {1'b0, act_h_blank} + 17'd1));

  assert_frame_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_start) |-> $past(dot_en));

  assert_timing_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable({act_h_sync, act_h_blank, act_h_screen, act_h_total,
                            act_v_sync, act_v_blank, act_v_screen, act_v_total}));

  assert_flip_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable({flip_x, flip_y}));

endmodule

bind raster_timing_gen raster_timing_gen_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dot_en      (dot_en),
  .hcount      (hcount),
  .vcount      (vcount),
  .hsync       (hsync),
  .hactive     (hactive),
  .frame_start (frame_start),
  .flip_x      (flip_x),
  .flip_y      (flip_y),
  .act_h_sync  (act_h_sync),
  .act_h_blank (act_h_blank),
  .act_h_screen(act_h_screen),
  .act_h_total (act_h_total),
  .act_v_sync  (act_v_sync),
  .act_v_blank (act_v_blank),
  .act_v_screen(act_v_screen),
  .act_v_total (act_v_total)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam int HS = 1, HB = 3, HSC = 8, HT = 10;
  localparam int VS = 0, VB = 1, VSC = 4, VT = 5;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rst_n, dot_en, reg_wr;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata, hcount, vcount;
  logic        hsync, hblank, hactive, vsync, vblank, vactive;
  logic        frame_start, flip_x, flip_y;

  logic        d_en, d_wr;
  logic [7:0]  d_addr;
  logic [15:0] d_wdata, d_rdata, d_hcount, d_vcount;
  logic        d_hsync, d_hblank, d_hactive, d_vsync, d_vblank, d_vactive;
  logic        d_frame, d_fx, d_fy;

  raster_timing_gen #(
    .H_SYNC_END(16'(HS)), .H_BLANK_END(16'(HB)), .H_SCREEN_END(16'(HSC)), .H_TOTAL_END(16'(HT)),
    .V_SYNC_END(16'(VS)), .V_BLANK_END(16'(VB)), .V_SCREEN_END(16'(VSC)), .V_TOTAL_END(16'(VT)),
    .CTRL_INIT(16'h0003)
  ) u_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hcount(hcount), .vcount(vcount),
    .hsync(hsync), .hblank(hblank), .hactive(hactive), .vsync(vsync), .vblank(vblank),
    .vactive(vactive), .frame_start(frame_start), .flip_x(flip_x), .flip_y(flip_y)
  );

  raster_timing_gen u_raster_timing_gen_dflt (
    .clk(clk), .rst_n(rst_n), .dot_en(d_en), .reg_wr(d_wr), .reg_addr(d_addr),
    .reg_wdata(d_wdata), .reg_rdata(d_rdata), .hcount(d_hcount), .vcount(d_vcount),
    .hsync(d_hsync), .hblank(d_hblank), .hactive(d_hactive), .vsync(d_vsync), .vblank(d_vblank),
    .vactive(d_vactive), .frame_start(d_frame), .flip_x(d_fx), .flip_y(d_fy)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int mh, mv;
  int a_hs, a_hb, a_hsc, a_ht, a_vs, a_vb, a_vsc, a_vt;
  logic a_fx, a_fy;
  logic [15:0] sh [17];

  function automatic int map_idx(input logic [7:0] a);
    if (a[0]) return -1;
    if (a >= 8'h60 && a <= 8'h7E) return (int'(a) - 'h60) / 2;
    if (a == 8'h80) return 16;
    return -1;
  endfunction

  function automatic logic [7:0] idx_addr(input int i);
    if (i == 16) return 8'h80;
    return 8'(8'h60 + 2 * i);
  endfunction

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    int  idx;
    bit  eha, eva;
    eha = (mh > a_hb) && (mh <= a_hsc) && (mh <= a_ht);
    eva = (mv > a_vb) && (mv <= a_vsc) && (mv <= a_vt);
    chk_eq("R2 hcount", hcount, mh);
    chk_eq("R3 vcount", vcount, mv);
    chk_eq("R4 hsync", hsync, mh <= a_hs);
    chk_eq("R4 vsync", vsync, mv <= a_vs);
    chk_eq("R5 hactive", hactive, eha);
    chk_eq("R5 hblank", hblank, !eha);
    chk_eq("R5 vactive", vactive, eva);
    chk_eq("R5 vblank", vblank, !eva);
    chk_eq("R6 frame_start", frame_start, (mh == 0) && (mv == 0));
    chk_eq("R10 flip_x", flip_x, a_fx);
    chk_eq("R10 flip_y", flip_y, a_fy);
    idx = map_idx(reg_addr);
    chk_eq("R8 readback", reg_rdata, (idx < 0) ? 0 : sh[idx]);
  endtask

  task automatic load_active();
    a_hs = sh[0]; a_hb = sh[1]; a_hsc = sh[2]; a_ht = sh[3];
    a_vs = sh[8]; a_vb = sh[9]; a_vsc = sh[10]; a_vt = sh[11];
    a_fx = sh[16][3]; a_fy = sh[16][4];
  endtask

  // drive one cycle, update the model at the edge, compare at the falling edge
  task automatic step(input logic en, input logic wr, input logic [7:0] a, input logic [15:0] d);
    bit hw, fw;
    int idx;
    dot_en = en; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    hw = en && (mh == a_ht);
    fw = hw && (mv == a_vt);
    if (en) mh = hw ? 0 : mh + 1;
    if (hw) mv = (mv == a_vt) ? 0 : mv + 1;
    if (fw) load_active();
    idx = map_idx(a);
    if (wr && idx >= 0) sh[idx] = d;
    @(negedge clk);
    check_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h60, 16'h0);
  endtask

  task automatic sweep_readback(input string tag);
    for (int i = 0; i < 17; i++) begin
      reg_addr = idx_addr(i);
      #1;
      chk_eq(tag, reg_rdata, sh[i]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit saw_past;
    int act_cnt;
    sh = '{16'(HS), 16'(HB), 16'(HSC), 16'(HT), 16'd0, 16'd0, 16'd1023, 16'd64,
           16'(VS), 16'(VB), 16'(VSC), 16'(VT), 16'd0, 16'd0, 16'd1023, 16'd64, 16'h0003};
    load_active();
    mh = 0; mv = 0;
    rst_n = 1'b0; dot_en = 1'b0; reg_wr = 1'b0; reg_addr = 8'h60; reg_wdata = '0;
    d_en = 1'b0; d_wr = 1'b0; d_addr = 8'h66; d_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1: reset state and defaults
    chk_eq("R1 hcount after reset", hcount, 0);
    chk_eq("R1 vcount after reset", vcount, 0);
    check_all();
    sweep_readback("R1 default readback");
    d_addr = 8'h60; #1; chk_eq("R1 default hsync end", d_rdata, 42);
    d_addr = 8'h62; #1; chk_eq("R1 default hblank end", d_rdata, 111);
    d_addr = 8'h64; #1; chk_eq("R1 default hscreen end", d_rdata, 495);
    d_addr = 8'h66; #1; chk_eq("R1 default htotal end", d_rdata, 454);
    d_addr = 8'h70; #1; chk_eq("R1 default vsync end", d_rdata, 3);
    d_addr = 8'h72; #1; chk_eq("R1 default vblank end", d_rdata, 21);
    d_addr = 8'h74; #1; chk_eq("R1 default vscreen end", d_rdata, 245);
    d_addr = 8'h76; #1; chk_eq("R1 default vtotal end", d_rdata, 262);
    d_addr = 8'h80; #1; chk_eq("R1 default control", d_rdata, 16'h0003);

    // R2..R6: continuous dots for two frames and a bit
    idle(2 * (HT + 1) * (VT + 1) + 5);

    // R2: gated dot enable
    for (int i = 0; i < 200; i++) step(((i * 7) % 3) != 0, 1'b0, 8'h60, 16'h0);

    // R7: rewrite timing mid-frame; old timing must persist to the wrap
    while (!(mv == 1 && mh == 2)) step(1'b1, 1'b0, 8'h60, 16'h0);
    step(1'b1, 1'b1, 8'h60, 16'd2);
    step(1'b1, 1'b1, 8'h62, 16'd2);
    step(1'b1, 1'b1, 8'h64, 16'd12);
    step(1'b1, 1'b1, 8'h66, 16'd7);
    step(1'b1, 1'b1, 8'h70, 16'd1);
    step(1'b1, 1'b1, 8'h72, 16'd0);
    step(1'b1, 1'b1, 8'h74, 16'd3);
    step(1'b1, 1'b1, 8'h76, 16'd3);
    step(1'b1, 1'b1, 8'h80, 16'h001D);
    saw_past = 0;
    for (int i = 0; i < 12; i++) begin
      if (hcount == 16'd9) saw_past = 1;
      step(1'b1, 1'b0, 8'h66, 16'h0);
    end
    chk_eq("R7 line still runs past new total before wrap", saw_past, 1);
    chk_eq("R7 flip_x still old before wrap", flip_x, 0);
    while (!(mh == 0 && mv == 0)) step(1'b1, 1'b0, 8'h80, 16'h0);
    chk_eq("R10 flip_x after wrap", flip_x, 1);
    chk_eq("R10 flip_y after wrap", flip_y, 1);
    idle(3 * 8 * 4);

    // R9: store-only words and spare control bits
    step(1'b1, 1'b1, 8'h68, 16'h1234);
    step(1'b1, 1'b1, 8'h6A, 16'hBEEF);
    step(1'b1, 1'b1, 8'h6C, 16'h0000);
    step(1'b1, 1'b1, 8'h6E, 16'hFFFF);
    step(1'b1, 1'b1, 8'h78, 16'h0F0F);
    step(1'b1, 1'b1, 8'h7A, 16'h00FF);
    step(1'b1, 1'b1, 8'h7C, 16'h8001);
    step(1'b1, 1'b1, 8'h7E, 16'h4242);
    step(1'b1, 1'b1, 8'h80, 16'h80FD);
    sweep_readback("R9 store-only readback");
    while (!(mh == 0 && mv == 0)) step(1'b1, 1'b0, 8'h60, 16'h0);
    act_cnt = 0;
    for (int i = 0; i < 2 * 8 * 4; i++) begin
      if (hactive && vactive) act_cnt++;
      step(1'b1, 1'b0, 8'h60, 16'h0);
    end
    chk_eq("R9 active dots over two frames", act_cnt, 2 * (7 - 2) * (3 - 0));
    chk_eq("R9 flip_x unchanged by spare bits", flip_x, 1);

    // R8: unmapped and odd offsets
    step(1'b1, 1'b1, 8'h90, 16'hFFFF);
    step(1'b1, 1'b1, 8'h61, 16'hFFFF);
    step(1'b1, 1'b1, 8'h5E, 16'hFFFF);
    step(1'b1, 1'b1, 8'h82, 16'hFFFF);
    step(1'b1, 1'b1, 8'h7F, 16'hFFFF);
    sweep_readback("R8 map unchanged after unmapped writes");

    // R2/R3: single-dot lines, vertical steps every dot
    step(1'b1, 1'b1, 8'h66, 16'd0);
    while (!(mh == 0 && mv == 0)) step(1'b1, 1'b0, 8'h60, 16'h0);
    idle(12);
    chk_eq("R3 one-dot line advances vcount each dot", vcount, 0);

    // R11: default instance line length
    dot_en = 1'b0; reg_wr = 1'b0;
    d_en = 1'b1;
    for (int n = 1; n <= 455; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n == 454) begin
        chk_eq("R11 hcount at line end", d_hcount, 454);
        chk_eq("R11 vcount still 0", d_vcount, 0);
      end
    end
    chk_eq("R11 hcount wrapped after 455 dots", d_hcount, 0);
    chk_eq("R11 vcount after 455 dots", d_vcount, 1);
    chk_eq("R11 frame_start low on line 1", d_frame, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule